// File: doc/BRIEF.md
# Bit-Test Branch Bus Sequencer

This block drives the memory bus, cycle by cycle, for the branch-on-bit-test instructions of an 8-bit processor core. The instruction decoder pulses `start` once it has fetched an opcode of this family. With that pulse it passes the upper nibble of the opcode and the program counter, which already points past the opcode byte. The sequencer then fetches a zero-page address byte and reads that zero-page location twice. Next it fetches a signed 8-bit displacement. It tests the bit of the zero-page data that the opcode selects.

When the branch is taken, the bus carries one or two extra read cycles that do nothing, and the displacement is added to the program counter. The result leaves on `pc_out` during a one-cycle `done` pulse, and the core resumes opcode fetch from that address. The read data bus returns the addressed byte in the same cycle as the read strobe.

Top module: `bbt_branch_seq`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `mem_rd` stay low and `pc_out` is zero until a sequence runs.
- R2: `op_sel[2:0]` (opcode bits 6:4) select the tested bit. `op_sel[3]` (opcode bit 7) picks the polarity: 0 branches when that bit is clear, 1 branches when it is set.
- R3: A sequence starts only from `start` while idle. Its first four bus reads go, in order, to PC, then `{ZP_PAGE, zp}`, then `{ZP_PAGE, zp}` again, then PC+1.
- R4: When the branch is not taken, exactly four read cycles occur and `pc_out` is PC+2.
- R5: When the branch is taken, a fifth read goes to PC+2 (the program counter after the displacement fetch, not incremented again), and `pc_out` is PC+2 plus the sign-extended displacement.
- R6: When the taken target lies in a different 256-byte page from PC+2, a sixth read goes to the address made of the high byte of PC+2 and the low byte of the target. Otherwise no sixth read occurs.
- R7: `done` is high for exactly one cycle, in the cycle right after the last read cycle, and `pc_out` holds the new PC during that cycle.
- R8: All PC arithmetic wraps modulo 65536, both when the PC increments and when the displacement is added.
- R9: A `start` pulse that arrives while a sequence is running is ignored. Bus addresses, cycle count and result stay those of the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a sequence |
| op_sel | input | 4 | Opcode bits 7:4: polarity in bit 3, bit index in bits 2:0 |
| pc_in | input | 16 | Address of the byte after the opcode |
| mem_addr | output | 16 | Bus address, meaningful while `mem_rd` is high |
| mem_rd | output | 1 | Read strobe, one per bus cycle |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter, valid while `done` is high |

## Verification
The assertions assume that `mem_rdata` answers a read in the same cycle it is strobed. They also assume that a fresh sequence begins only from a `start` sampled in the idle state, so every rising read strobe has a start pulse one cycle before it. The bench keeps to this in three ways. Its memory model is combinational over `mem_addr`. It changes inputs only at the falling clock edge. Its extra start pulses arrive in the middle of a sequence, where the design must drop them.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ZP_FETCH  = 3'd1,
        ST_ZP_READ   = 3'd2,
        ST_ZP_REREAD = 3'd3,
        ST_OFS_FETCH = 3'd4,
        ST_DUMMY     = 3'd5,
        ST_CROSS     = 3'd6,
        ST_DONE      = 3'd7
    } bbt_state_e;

endpackage

// File: rtl/bbt_bit_select.sv
module bbt_bit_select #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              want_set,
    output logic              taken
);
    logic [DATA_W-1:0] hit;

    for (genvar g = 0; g < DATA_W; g++) begin : g_hit
        assign hit[g] = (idx == IDX_W'(g)) & data[g];
    end

    logic sel_bit;
    assign sel_bit = |hit;
    assign taken   = want_set ? sel_bit : ~sel_bit;

endmodule

// File: rtl/bbt_branch_target.sv
module bbt_branch_target #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] ofs,
    output logic [ADDR_W-1:0] target,
    output logic              crosses,
    output logic [ADDR_W-1:0] cross_addr
);
    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext    = {{HI_W{ofs[DATA_W-1]}}, ofs};
    assign target     = pc + ofs_ext;
    assign crosses    = target[ADDR_W-1:DATA_W] != pc[ADDR_W-1:DATA_W];
    assign cross_addr = {pc[ADDR_W-1:DATA_W], target[DATA_W-1:0]};

endmodule

// File: rtl/bbt_branch_seq.sv
module bbt_branch_seq
    import bbt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-DATA_W-1:0] ZP_PAGE = '0,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W:0]    op_sel,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out
);
    typedef struct packed {
        bbt_state_e        state;
        logic              want_set;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] zp;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] ofs;
    } regs_t;

    localparam regs_t REGS_RESET = '{state: ST_IDLE, default: '0};

    regs_t r_d, r_q;

    logic              taken;
    logic [ADDR_W-1:0] target;
    logic              crosses;
    logic [ADDR_W-1:0] cross_addr;
    logic [ADDR_W-1:0] zp_addr;

    assign zp_addr = {ZP_PAGE, r_q.zp};

    bbt_bit_select #(.DATA_W(DATA_W)) i_bit_select (
        .data     (r_q.data),
        .idx      (r_q.idx),
        .want_set (r_q.want_set),
        .taken    (taken)
    );

    bbt_branch_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_branch_target (
        .pc         (r_q.pc),
        .ofs        (r_q.ofs),
        .target     (target),
        .crosses    (crosses),
        .cross_addr (cross_addr)
    );

    always_comb begin
        r_d      = r_q;
        mem_rd   = 1'b0;
        mem_addr = r_q.pc;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.pc       = pc_in;
                    r_d.want_set = op_sel[IDX_W];
                    r_d.idx      = op_sel[IDX_W-1:0];
                    r_d.state    = ST_ZP_FETCH;
                end
            end
            ST_ZP_FETCH: begin
                mem_rd    = 1'b1;
                mem_addr  = r_q.pc;
                r_d.zp    = mem_rdata;
                r_d.pc    = r_q.pc + ADDR_W'(1);
                r_d.state = ST_ZP_READ;
            end
            ST_ZP_READ: begin
                mem_rd    = 1'b1;
                mem_addr  = zp_addr;
                r_d.data  = mem_rdata;
                r_d.state = ST_ZP_REREAD;
            end
            ST_ZP_REREAD: begin
                mem_rd    = 1'b1;
                mem_addr  = zp_addr;
                r_d.state = ST_OFS_FETCH;
            end
            ST_OFS_FETCH: begin
                mem_rd    = 1'b1;
                mem_addr  = r_q.pc;
                r_d.ofs   = mem_rdata;
                r_d.pc    = r_q.pc + ADDR_W'(1);
                r_d.state = taken ? ST_DUMMY : ST_DONE;
            end
            ST_DUMMY: begin
                mem_rd   = 1'b1;
                mem_addr = r_q.pc;
                if (crosses) begin
                    r_d.state = ST_CROSS;
                end else begin
                    r_d.pc    = target;
                    r_d.state = ST_DONE;
                end
            end
            ST_CROSS: begin
                mem_rd    = 1'b1;
                mem_addr  = cross_addr;
                r_d.pc    = target;
                r_d.state = ST_DONE;
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign done   = (r_q.state == ST_DONE);
    assign pc_out = r_q.pc;

    // A sequence only opens on an accepted start
    assert_rd_opens_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> $past(start));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && r_q.state != ST_IDLE) |=> (r_q.state != ST_ZP_FETCH));

    assert_dummy_at_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DUMMY) |-> (mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_cross_keeps_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CROSS) |->
            (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_rd) && !mem_rd));

endmodule

// File: tb/test_bbt_branch_seq.sv
module test_bbt_branch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] pc;
        logic [7:0]  zp;
        logic [7:0]  dat;
        logic [7:0]  ofs;
        logic [3:0]  nbus;
        logic [15:0] npc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h0F, 16'h1000, 8'h10, 8'h01, 8'h10, 4'd4, 16'h1002},
        '{8'h8F, 16'h1000, 8'h10, 8'h01, 8'h10, 4'd5, 16'h1012},
        '{8'h7F, 16'h10F0, 8'h20, 8'h7F, 8'h20, 4'd6, 16'h1112},
        '{8'hFF, 16'h2000, 8'h30, 8'h7F, 8'h80, 4'd4, 16'h2002},
        '{8'hBF, 16'h3000, 8'h31, 8'h08, 8'hFE, 4'd5, 16'h3000},
        '{8'h2F, 16'h3005, 8'h32, 8'hFB, 8'h80, 4'd6, 16'h2F87},
        '{8'hCF, 16'hFFF0, 8'h33, 8'h10, 8'h7F, 4'd6, 16'h0071},
        '{8'h5F, 16'hFFFE, 8'h40, 8'h20, 8'h05, 4'd4, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_rdata;
    logic        done;
    logic [15:0] pc_out;

    logic [15:0] cur_pc = '0;
    logic [7:0]  cur_zp = '0, cur_dat = '0, cur_ofs = '0;

    int nchecks = 0;
    int nerr = 0;
    int wd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bbt_branch_seq i_bbt_branch_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_sel    (op_sel),
        .pc_in     (pc_in),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .done      (done),
        .pc_out    (pc_out)
    );

    always_comb begin
        if (mem_addr == cur_pc)                  mem_rdata = cur_zp;
        else if (mem_addr == {8'h00, cur_zp})    mem_rdata = cur_dat;
        else if (mem_addr == cur_pc + 16'd1)     mem_rdata = cur_ofs;
        else                                     mem_rdata = 8'hEA;
    end

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke);
        logic [15:0] addrs [8];
        logic [15:0] exp_a [6];
        logic [15:0] p2;
        int nbus;
        int cyc;
        cur_pc  = v.pc;
        cur_zp  = v.zp;
        cur_dat = v.dat;
        cur_ofs = v.ofs;
        for (int i = 0; i < 8; i++) addrs[i] = '0;
        @(negedge clk);
        start  = 1'b1;
        op_sel = v.op[7:4];
        pc_in  = v.pc;
        @(negedge clk);
        start = 1'b0;
        cyc   = 1;
        nbus  = 0;
        while (!done && cyc < 20) begin
            if (mem_rd) begin
                if (nbus < 8) addrs[nbus] = mem_addr;
                nbus++;
            end
            if (poke && (cyc == 2 || cyc == 4)) begin
                start  = 1'b1;
                op_sel = 4'h0;
                pc_in  = 16'h5555;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done == 1'b1, "R7 done seen", 32'(done), 32'd1);
        check(cyc == int'(v.nbus) + 1, "R4/R5/R6/R7 cycles start to done",
              32'(cyc), 32'(int'(v.nbus) + 1));
        check(nbus == int'(v.nbus), "R2/R4/R5/R6 bus read count",
              32'(nbus), 32'(v.nbus));
        check(pc_out == v.npc, "R4/R5/R8 new pc", 32'(pc_out), 32'(v.npc));
        p2 = v.pc + 16'd2;
        exp_a[0] = v.pc;
        exp_a[1] = {8'h00, v.zp};
        exp_a[2] = {8'h00, v.zp};
        exp_a[3] = v.pc + 16'd1;
        exp_a[4] = p2;
        exp_a[5] = {p2[15:8], v.npc[7:0]};
        for (int i = 0; i < 6; i++) begin
            if (i < nbus) begin
                check(addrs[i] == exp_a[i], "R3/R5/R6 bus address order",
                      32'(addrs[i]), 32'(exp_a[i]));
            end
        end
        if (poke) begin
            check(pc_out != 16'h5557 && nbus == int'(v.nbus),
                  "R9 start during sequence ignored", 32'(pc_out), 32'(v.npc));
        end
        @(negedge clk);
        check(done == 1'b0, "R7 done lasts one cycle", 32'(done), 32'd0);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > WATCHDOG) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", wd, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done low in reset", 32'(done), 32'd0);
        check(mem_rd == 1'b0, "R1 mem_rd low in reset", 32'(mem_rd), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b0 && mem_rd == 1'b0, "R1 idle after reset",
              32'({done, mem_rd}), 32'd0);
        check(pc_out == 16'h0000, "R1 pc_out zero after reset", 32'(pc_out), 32'd0);

        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], 1'b0);
        end

        // R9: start pulses while busy, on a taken page-crossing case
        run_vec(VECS[2], 1'b1);
        // R9: start pulses while busy, on a not-taken case
        run_vec(VECS[0], 1'b1);

        // R2: every bit index, both polarities, single-bit data
        for (int b = 0; b < 8; b++) begin
            vec_t v;
            v.op   = {1'b1, 3'(b), 4'hF};
            v.pc   = 16'h4000;
            v.zp   = 8'h50;
            v.dat  = 8'(1 << b);
            v.ofs  = 8'h04;
            v.nbus = 4'd5;
            v.npc  = 16'h4006;
            run_vec(v, 1'b0);
            v.op   = {1'b0, 3'(b), 4'hF};
            v.nbus = 4'd4;
            v.npc  = 16'h4002;
            run_vec(v, 1'b0);
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    end

endmodule